// File: doc/BRIEF.md
# Slope-Extrapolating Gamma Table

This block is the gamma stage of a display pipe. Each pixel carries three 10-bit colour components (red, green, blue). Each component is mapped to a 10-bit output through a table that software loads through a simple word-wide write and read port.

Two table formats are supported, and the format is picked for each pixel by a mode input.

- **Precision mode.** The 10-bit curve is described by 129 points, of which only 128 are held in storage. Each stored entry carries a base value and a compact floating-point slope. An output between two points is extrapolated forward from the entry below it using only that entry's own slope. The final curve point is therefore implied by entry 127 and is never stored.
- **Palette mode.** Each component indexes a 256-word palette with 8 bits per channel.

Both formats share one 256-word store. Results appear a fixed two clocks after the input, with a valid flag travelling alongside the data.

Top module: `gamma_slope_lut`

## Requirements
- R1: A pixel presented with `pix_valid` high appears on the outputs with `out_valid` high exactly two clock edges later. `out_valid` is low in every other cycle.
- R2: A read strobe returns the word last written at that index on `reg_rdata` after the next clock edge. Bits 23:0 are as written and bits 31:24 read as zero.
- R3: For indices 256 and above, writes are ignored and reads return zero.
- R4: Palette mode (`mode_10b`=0) uses a per-channel palette.
  - Each component's upper 8 bits select a word.
  - The channel byte sits in bits 23:16 for red, 15:8 for green and 7:0 for blue.
  - The output is that byte followed by the byte's top two bits.
- R5: Precision mode (`mode_10b`=1) uses an entry pair.
  - The component's upper 7 bits select entry k, which is held in word 2k and word 2k+1, using the same byte lanes as R4.
  - The base value is formed from bits 1:0 of the odd byte, placed above the 8 bits of the even byte.
- R6: In precision mode, the slope is taken from the odd byte.
  - The exponent e is bits 7:6 and the mantissa m is bits 5:2.
  - The rise over an interval is m·8/2^e.
  - With f the component's low 3 bits, the output is base + floor(rise·f/8).
  - No other entry affects the result.
- R7: A precision-mode result above 1023 is clamped to 1023.
- R8: While `out_valid` is low, the output components keep their last values.
- R9: During reset, `out_valid`, the output components and `reg_rdata` are cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_10b | input | 1 | 1 selects precision mode, 0 selects palette mode; sampled with the pixel |
| pix_valid | input | 1 | Input pixel qualifier |
| pix_r | input | 10 | Red component in |
| pix_g | input | 10 | Green component in |
| pix_b | input | 10 | Blue component in |
| reg_wr | input | 1 | Table write strobe |
| reg_rd | input | 1 | Table read strobe |
| reg_addr | input | 9 | Word index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, registered |
| out_valid | output | 1 | Output pixel qualifier |
| out_r | output | 10 | Red component out |
| out_g | output | 10 | Green component out |
| out_b | output | 10 | Blue component out |

## Verification
A wrong entry-pair address or a swapped byte lane shows up as a wrong output component. It appears on the second edge after a pixel that lands in the affected interval. Random table contents and pixels therefore expose it within a few hundred pixels.

A mis-decoded exponent or mantissa, or a missing clamp, corrupts only nonzero fractions or the top of the range. Directed pixels at fraction 0 and 7, at the saturating base and at the last entry pin these down.

A wrong pipeline stage count misplaces `out_valid` on the first pixel checked.

// File: rtl/gamma_pkg.sv
package gamma_pkg;

    parameter int PIX_W     = 10;
    parameter int CH_W      = 8;
    parameter int NUM_CH    = 3;
    parameter int WORD_W    = 32;
    parameter int NUM_WORDS = 256;
    parameter int ADDR_W    = 9;
    parameter int FRAC_W    = 3;
    parameter int EXP_W     = 2;
    parameter int MANT_W    = 4;

    localparam int STORE_W   = NUM_CH * CH_W;
    localparam int WA_W      = $clog2(NUM_WORDS);
    localparam int IDX_W     = PIX_W - FRAC_W;
    localparam int HI_W      = PIX_W - CH_W;
    localparam int MAX_SHIFT = (2 ** EXP_W) - 1;
    localparam int RISE_W    = MANT_W + MAX_SHIFT;
    localparam int NLOOK     = 2 * NUM_CH;

    typedef logic [PIX_W-1:0] pix_t;

    typedef struct packed {
        logic [EXP_W-1:0]  expo;
        logic [MANT_W-1:0] mant;
        logic [HI_W-1:0]   hi;
    } slope_byte_t;

    typedef struct packed {
        logic                    valid;
        logic                    ten_bit;
        pix_t [NUM_CH-1:0]       comp;
    } px_beat_t;

    function automatic logic [RISE_W-1:0] slope_rise(logic [EXP_W-1:0] expo,
                                                     logic [MANT_W-1:0] mant);
        logic [EXP_W-1:0] sh;
        sh = EXP_W'(MAX_SHIFT) - expo;
        return RISE_W'(mant) << sh;
    endfunction

    function automatic pix_t extrapolate(pix_t base,
                                         logic [RISE_W-1:0] rise,
                                         logic [FRAC_W-1:0] frac);
        logic [RISE_W+FRAC_W-1:0] prod;
        logic [PIX_W:0]           sum;
        prod = (RISE_W+FRAC_W)'(rise) * (RISE_W+FRAC_W)'(frac);
        sum  = (PIX_W+1)'(base) + (PIX_W+1)'(prod >> FRAC_W);
        return sum[PIX_W] ? '1 : sum[PIX_W-1:0];
    endfunction

endpackage

// File: rtl/gamma_word_store.sv
module gamma_word_store
    import gamma_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst,
    input  logic                         wr_en,
    input  logic                         rd_en,
    input  logic [ADDR_W-1:0]            addr,
    input  logic [WORD_W-1:0]            wr_data,
    output logic [WORD_W-1:0]            rd_data,
    input  logic [NLOOK-1:0][WA_W-1:0]   look_addr,
    output logic [NLOOK-1:0][STORE_W-1:0] look_data
);

    logic [STORE_W-1:0] mem [NUM_WORDS];
    logic               in_range;
    logic [WA_W-1:0]    word_idx;
    logic               unused_hi;

    assign in_range  = (addr < ADDR_W'(NUM_WORDS));
    assign word_idx  = addr[WA_W-1:0];
    assign unused_hi = ^wr_data[WORD_W-1:STORE_W];

    always_ff @(posedge clk) begin
        if (wr_en && in_range)
            mem[word_idx] <= wr_data[STORE_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (rst)
            rd_data <= '0;
        else if (rd_en)
            rd_data <= in_range ? WORD_W'(mem[word_idx]) : '0;
    end

    for (genvar p = 0; p < NLOOK; p++) begin : g_look
        assign look_data[p] = mem[look_addr[p]];
    end

endmodule

// File: rtl/gamma_chan_eval.sv
module gamma_chan_eval
    import gamma_pkg::*;
(
    input  logic              ten_bit,
    input  logic [FRAC_W-1:0] frac,
    input  logic [CH_W-1:0]   even_byte,
    input  logic [CH_W-1:0]   odd_byte,
    output pix_t              result
);

    slope_byte_t       sb;
    pix_t              base;
    logic [RISE_W-1:0] rise;

    assign sb   = slope_byte_t'(odd_byte);
    assign base = {sb.hi, even_byte};
    assign rise = slope_rise(sb.expo, sb.mant);

    always_comb begin
        if (ten_bit)
            result = extrapolate(base, rise, frac);
        else
            result = {even_byte, even_byte[CH_W-1 -: HI_W]};
    end

endmodule

// File: rtl/gamma_slope_lut.sv
module gamma_slope_lut
    import gamma_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mode_10b,
    input  logic              pix_valid,
    input  logic [PIX_W-1:0]  pix_r,
    input  logic [PIX_W-1:0]  pix_g,
    input  logic [PIX_W-1:0]  pix_b,
    input  logic              reg_wr,
    input  logic              reg_rd,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              out_valid,
    output logic [PIX_W-1:0]  out_r,
    output logic [PIX_W-1:0]  out_g,
    output logic [PIX_W-1:0]  out_b
);

    px_beat_t                     s1;
    logic [NLOOK-1:0][WA_W-1:0]   look_addr;
    logic [NLOOK-1:0][STORE_W-1:0] look_data;
    pix_t [NUM_CH-1:0]            calc;
    pix_t [NUM_CH-1:0]            out_q;

    // stage 1: capture the pixel and its mode
    always_ff @(posedge clk) begin
        if (rst)
            s1 <= '0;
        else begin
            s1.valid   <= pix_valid;
            s1.ten_bit <= mode_10b;
            if (pix_valid)
                s1.comp <= {pix_r, pix_g, pix_b};
        end
    end

    gamma_word_store u_store (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (reg_wr),
        .rd_en    (reg_rd),
        .addr     (reg_addr),
        .wr_data  (reg_wdata),
        .rd_data  (reg_rdata),
        .look_addr(look_addr),
        .look_data(look_data)
    );

    // per channel: even (or palette) word and odd word lookups
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic [IDX_W-1:0] entry;
        assign entry = s1.comp[c][PIX_W-1 -: IDX_W];
        assign look_addr[2*c]   = s1.ten_bit ? WA_W'({entry, 1'b0})
                                             : WA_W'(s1.comp[c][PIX_W-1 -: CH_W]);
        assign look_addr[2*c+1] = WA_W'({entry, 1'b1});

        gamma_chan_eval u_eval (
            .ten_bit  (s1.ten_bit),
            .frac     (s1.comp[c][FRAC_W-1:0]),
            .even_byte(look_data[2*c][c*CH_W +: CH_W]),
            .odd_byte (look_data[2*c+1][c*CH_W +: CH_W]),
            .result   (calc[c])
        );
    end

    // stage 2: registered result
    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid <= 1'b0;
            out_q     <= '0;
        end else begin
            out_valid <= s1.valid;
            if (s1.valid)
                out_q <= calc;
        end
    end

    assign out_r = out_q[2];
    assign out_g = out_q[1];
    assign out_b = out_q[0];

endmodule

// File: rtl/gamma_slope_lut_chk.sv
module gamma_slope_lut_chk
    import gamma_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              mode_10b,
    input logic              pix_valid,
    input logic              reg_rd,
    input logic [ADDR_W-1:0] reg_addr,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              out_valid,
    input logic [PIX_W-1:0]  out_r,
    input logic [PIX_W-1:0]  out_g,
    input logic [PIX_W-1:0]  out_b
);

    logic [1:0] since_rst;

    always_ff @(posedge clk) begin
        if (rst)
            since_rst <= '0;
        else if (since_rst != 2'd3)
            since_rst <= since_rst + 2'd1;
    end

    AST_TWO_CYCLE_VALID: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2) |-> (out_valid == $past(pix_valid, 2))); // R1

    AST_HIGH_READ_ZERO: assert property (@(posedge clk) disable iff (rst)
        (reg_rd && reg_addr >= ADDR_W'(NUM_WORDS)) |=> (reg_rdata == '0)); // R3

    AST_PALETTE_REPLICATE: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd2 && out_valid && !$past(mode_10b, 2)) |->
        (out_r[1:0] == out_r[9:8] && out_g[1:0] == out_g[9:8] && out_b[1:0] == out_b[9:8])); // R4

    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst)
        (since_rst >= 2'd1 && !out_valid) |->
        ($stable(out_r) && $stable(out_g) && $stable(out_b))); // R8

    AST_RESET_CLEAR: assert property (@(posedge clk)
        rst |=> (!out_valid && out_r == '0 && out_g == '0 && out_b == '0 && reg_rdata == '0)); // R9

endmodule

bind gamma_slope_lut gamma_slope_lut_chk u_chk (
    .clk      (clk),
    .rst      (rst),
    .mode_10b (mode_10b),
    .pix_valid(pix_valid),
    .reg_rd   (reg_rd),
    .reg_addr (reg_addr),
    .reg_rdata(reg_rdata),
    .out_valid(out_valid),
    .out_r    (out_r),
    .out_g    (out_g),
    .out_b    (out_b)
);

// File: tb/gamma_slope_lut_bench.sv
module gamma_slope_lut_bench;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        mode_10b = 1'b0;
    logic        pix_valid = 1'b0;
    logic [9:0]  pix_r = '0, pix_g = '0, pix_b = '0;
    logic        reg_wr = 1'b0, reg_rd = 1'b0;
    logic [8:0]  reg_addr = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic        out_valid;
    logic [9:0]  out_r, out_g, out_b;

    int n_chk = 0;
    int n_bad = 0;
    logic [23:0] shadow [256];

    always #10 clk = ~clk;

    gamma_slope_lut u_gamma_slope_lut (
        .clk(clk), .rst(rst), .mode_10b(mode_10b), .pix_valid(pix_valid),
        .pix_r(pix_r), .pix_g(pix_g), .pix_b(pix_b),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .out_valid(out_valid), .out_r(out_r), .out_g(out_g), .out_b(out_b)
    );

    task automatic check(input string req, input int act, input int exp_v);
        n_chk++;
        if (act !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp_v);
        end
    endtask

    // lane 2 = red, 1 = green, 0 = blue
    function automatic int model(int lane, logic ten, logic [9:0] v);
        logic [7:0] e, o;
        int base, rise, s;
        if (!ten) begin
            e = shadow[v >> 2][lane*8 +: 8];
            return {e, e[7:6]};
        end
        e    = shadow[2 * (v >> 3)][lane*8 +: 8];
        o    = shadow[2 * (v >> 3) + 1][lane*8 +: 8];
        base = {o[1:0], e};
        rise = int'(o[5:2]) * (8 >> o[7:6]);
        s    = base + (rise * int'(v[2:0])) / 8;
        return (s > 1023) ? 1023 : s;
    endfunction

    task automatic wr(input int a, input logic [31:0] d);
        reg_addr = 9'(a); reg_wdata = d; reg_wr = 1'b1;
        @(negedge clk);
        reg_wr = 1'b0;
        if (a < 256) shadow[a] = d[23:0];
    endtask

    task automatic rd(input int a, input logic [31:0] exp_v, input string req);
        reg_addr = 9'(a); reg_rd = 1'b1;
        @(negedge clk);
        reg_rd = 1'b0;
        check(req, int'(reg_rdata), int'(exp_v));
    endtask

    task automatic px(input logic ten, input logic [9:0] r, input logic [9:0] g,
                      input logic [9:0] b, input string req);
        mode_10b = ten; pix_r = r; pix_g = g; pix_b = b; pix_valid = 1'b1;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R1 valid not early", int'(out_valid), 0);
        pix_r = ~r; pix_g = ~g; pix_b = ~b; mode_10b = ~ten;
        @(negedge clk);
        check("R1 valid at two edges", int'(out_valid), 1);
        check({req, " red"},   int'(out_r), model(2, ten, r));
        check({req, " green"}, int'(out_g), model(1, ten, g));
        check({req, " blue"},  int'(out_b), model(0, ten, b));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [9:0] hr, hg, hb;
        void'($urandom(32'd20240607));
        repeat (3) @(negedge clk);
        // R9 reset state
        check("R9 out_valid", int'(out_valid), 0);
        check("R9 out_r", int'(out_r), 0);
        check("R9 rdata", int'(reg_rdata), 0);
        rst = 1'b0;
        @(negedge clk);

        // fill the table, upper byte of write data random
        for (int i = 0; i < 256; i++) wr(i, $urandom());
        // R2 readback, bits 31:24 zero
        for (int i = 0; i < 256; i += 17) rd(i, {8'h0, shadow[i]}, "R2 readback");
        rd(255, {8'h0, shadow[255]}, "R2 readback top");

        // R3: out-of-range write ignored, read gives zero
        begin
            logic [23:0] keep;
            keep = shadow[44];
            wr(300, 32'hFFFF_FFFF);
            rd(300, 32'h0, "R3 high read zero");
            rd(44, {8'h0, keep}, "R3 no alias write");
            wr(511, 32'h00AB_CDEF);
            rd(511, 32'h0, "R3 top index read zero");
            rd(255, {8'h0, shadow[255]}, "R3 no alias top");
        end

        // R5/R6 directed: entry 5, red base 0x2AB, e=0 m=15; green e=3 m=1; blue e=1 m=9
        wr(10, 32'h00AB_3412);
        wr(11, {8'h0, 8'b00_1111_10, 8'b11_0001_01, 8'b01_1001_00});
        px(1'b1, 10'(5*8+0), 10'(5*8+0), 10'(5*8+0), "R5 base at frac0");
        px(1'b1, 10'(5*8+7), 10'(5*8+7), 10'(5*8+7), "R6 frac7 slope");
        check("R6 red directed value", int'(out_r), 'h2AB + 105);
        px(1'b1, 10'(5*8+3), 10'(5*8+4), 10'(5*8+5), "R6 mid fractions");
        // R6 neighbour independence: change entry 6 and recheck entry 5
        wr(12, 32'h00FF_FFFF); wr(13, 32'h00FF_FFFF);
        px(1'b1, 10'(5*8+7), 10'(5*8+6), 10'(5*8+1), "R6 next entry unused");
        check("R6 red unchanged", int'(out_r), 'h2AB + 105);

        // R7 saturation at entry 127 (last stored point), base 1020, steep slope
        wr(254, 32'h00FC_FC00);
        wr(255, {8'h0, 8'b00_1111_11, 8'b00_1111_11, 8'b00_0000_00});
        px(1'b1, 10'd1023, 10'd1016, 10'd1023, "R7 saturate last entry");
        check("R7 red clamp", int'(out_r), 1023);
        check("R7 green frac0", int'(out_g), 1020);
        check("R7 blue zero", int'(out_b), 0);

        // R4 palette mode directed: word 0x55
        wr('h55, 32'h00C0_3F81);
        px(1'b0, 10'('h55 << 2), 10'(('h55 << 2) | 3), 10'(('h55 << 2) | 1), "R4 palette lanes");
        check("R4 red byte C0", int'(out_r), {8'hC0, 2'b11});

        // R8 hold: idle inputs change, outputs keep values
        hr = out_r; hg = out_g; hb = out_b;
        pix_r = 10'h3FF; pix_g = 10'h000; pix_b = 10'h155; mode_10b = 1'b1;
        repeat (3) @(negedge clk);
        check("R8 hold valid", int'(out_valid), 0);
        check("R8 hold red", int'(out_r), int'(hr));
        check("R8 hold green", int'(out_g), int'(hg));
        check("R8 hold blue", int'(out_b), int'(hb));

        // random precision and palette pixels over fresh random tables
        for (int i = 0; i < 256; i++) wr(i, $urandom());
        for (int n = 0; n < 300; n++)
            px(1'b1, 10'($urandom()), 10'($urandom()), 10'($urandom()), "R5 R6 R7 random precision");
        for (int n = 0; n < 300; n++)
            px(1'b0, 10'($urandom()), 10'($urandom()), 10'($urandom()), "R4 random palette");
        for (int n = 0; n < 200; n++)
            px(1'($urandom()), 10'($urandom()), 10'($urandom()), 10'($urandom()), "R4 R5 mixed modes");

        // back-to-back pixels: R1 with a stream
        mode_10b = 1'b1; pix_valid = 1'b1;
        pix_r = 10'd100; pix_g = 10'd200; pix_b = 10'd300;
        @(negedge clk);
        pix_r = 10'd900; pix_g = 10'd17; pix_b = 10'd555;
        @(negedge clk);
        pix_valid = 1'b0;
        check("R1 stream first", int'(out_r), model(2, 1'b1, 10'd100));
        @(negedge clk);
        check("R1 stream second", int'(out_b), model(0, 1'b1, 10'd555));
        check("R1 stream valid", int'(out_valid), 1);
        @(negedge clk);
        check("R1 stream end", int'(out_valid), 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule